// File: doc/BRIEF.md
# Eight-bit timer with assignable prescaler

This block is an 8-bit up-counter that never stops. It has no run/stop control, so it advances whenever its chosen clock source produces a tick. A small option register picks the tick source, which is either the instruction-cycle enable or an edge on an external count pin. The edge polarity is also selectable. A single 3-bit-rate prescaler is shared between the timer and a watchdog base tick, and the option register decides which of the two it serves. When the prescaler is given to the timer, the timer ratios run from 1:2 to 1:256. When it is given to the watchdog, the watchdog ratios run from 1:1 to 1:128, one power of two lower for the same code. The side that does not own the prescaler runs at 1:1.

Every wrap from 0xFF to 0x00 sets a sticky overflow flag. This happens whether or not anything downstream is interested in that event. The flag clears only through a software write. Interrupt gating, watchdog timeout counting and sleep handling sit outside this block. Software loads the counter, the option register and the flag through one write port selected by a 2-bit code.

Top module: `cnt8_presc_timer`

## Requirements
- R1: After reset the counter reads 0 and the flag reads 0. The option register resets to all ones: external source, falling edge, prescaler on the watchdog, rate 7. With the pin held still, the counter therefore does not move even when the instruction enable is high.
- R2: With option bit 0 = 0 and option bit 2 = 1, the counter advances by exactly one on every clock where `icyc_en` is 1, and holds otherwise. There is no stop control.
- R3: A step from 0xFF to 0x00 sets `ovf_flag`. The flag stays set across later counting.
- R4: A write with `wr_sel` = 2 loads `wr_data[0]` into the flag. If a write of 0 lands on the same clock as a wrap, the wrap wins and the flag stays 1.
- R5: With option bit 0 = 1, the counter counts edges of `ext_pin` after a two-stage synchronizer. Option bit 1 = 0 selects rising edges and bit 1 = 1 selects falling edges. In this mode `icyc_en` has no effect.
- R6: With option bit 2 = 0, the timer advances once per 2^(rate+1) source ticks, where rate is option bits 5:3.
- R7: With option bit 2 = 1, `wdt_tick` pulses once per 2^rate `wdt_base` pulses. With bit 2 = 0, `wdt_tick` equals `wdt_base`, and `wdt_base` never reaches the timer.
- R8: A write with `wr_sel` = 0 loads `wr_data` into the counter and takes priority over a same-clock increment. When the prescaler is on the timer, this write also clears the prescaler count.
- R9: A write with `wr_sel` = 1 loads `wr_data[5:0]` into the option register. Bit 0 is the source, bit 1 is the edge, bit 2 is the assignment and bits 5:3 are the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| icyc_en | input | 1 | Instruction-cycle enable, internal tick source |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_base | input | 1 | Watchdog base tick into the shared prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 option, 2 flag |
| wr_data | input | 8 | Write data |
| count_q | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Watchdog-side tick after prescaler or bypass |

## Verification
A prescaler count that is not cleared by a counter write only shows up at the ports a few ticks later: the counter advances early, one to 2^(rate+1) source ticks after the write. The bench therefore checks the count just before the first legal advance. A wrong ratio decode moves the count or the watchdog tick off its expected multiple within one full ratio period. The bench uses both the smallest and the largest rate. A flag that clears on its own, or that loses the tie against a clearing write, is visible on the very next clock.

// File: rtl/cnt8_pkg.sv
package cnt8_pkg;
   typedef enum logic [1:0] {
      SEL_CNT  = 2'd0,
      SEL_OPT  = 2'd1,
      SEL_FLAG = 2'd2
   } wsel_e;

   localparam int OPT_SRC      = 0;
   localparam int OPT_EDGE     = 1;
   localparam int OPT_PSA      = 2;
   localparam int OPT_RATE_LSB = 3;
endpackage

// File: rtl/cnt8_edge_sync.sv
module cnt8_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cnt8_edge_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= pin;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];

   always_comb begin
      if (fall_sel) edge_o = prev_q & ~chain_q[STAGES-1];
      else          edge_o = chain_q[STAGES-1] & ~prev_q;
   end
endmodule

// File: rtl/cnt8_prescaler.sv
module cnt8_prescaler #(
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_tick,
   input  logic              clr,
   input  logic              for_timer,
   input  logic [RATE_W-1:0] rate,
   output logic              tick_o
);
   localparam int PRE_W = 2 ** RATE_W;
   localparam int K_W   = RATE_W + 1;

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] mask;
   logic [K_W-1:0]   k_w;

   // timer side uses one more divide stage than the watchdog side
   always_comb begin
      if (for_timer) k_w = {1'b0, rate} + 1'b1;
      else           k_w = {1'b0, rate};
   end

   generate
      for (genvar g = 0; g < PRE_W; g++) begin : g_mask
         assign mask[g] = (k_w > K_W'(g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (in_tick) cnt_q <= cnt_q + 1'b1;

   assign tick_o = in_tick && ((cnt_q & mask) == mask);
endmodule

// File: rtl/cnt8_presc_timer.sv
module cnt8_presc_timer #(
   parameter int CNT_W       = 8,
   parameter int RATE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             icyc_en,
   input  logic             ext_pin,
   input  logic             wdt_base,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_q,
   output logic             ovf_flag,
   output logic             wdt_tick
);
   import cnt8_pkg::*;

   localparam int OPT_W = OPT_RATE_LSB + RATE_W;

   generate
      if (RATE_W < 1 || RATE_W > 4) begin : g_bad_rate
         $error("cnt8_presc_timer: RATE_W out of range 1..4");
      end
      if (CNT_W < OPT_W) begin : g_bad_width
         $error("cnt8_presc_timer: CNT_W too narrow for option field");
      end
   endgenerate

   logic [OPT_W-1:0]  opt_q;
   logic              src_ext, edge_fall, psa_sel;
   logic [RATE_W-1:0] rate_sel;
   logic              cnt_wr, opt_wr, flag_wr;
   logic              pin_edge, src_tick, pre_in, pre_tick, tmr_tick, wrap;

   assign src_ext   = opt_q[OPT_SRC];
   assign edge_fall = opt_q[OPT_EDGE];
   assign psa_sel   = opt_q[OPT_PSA];
   assign rate_sel  = opt_q[OPT_RATE_LSB +: RATE_W];

   assign cnt_wr  = wr_en && (wr_sel == SEL_CNT);
   assign opt_wr  = wr_en && (wr_sel == SEL_OPT);
   assign flag_wr = wr_en && (wr_sel == SEL_FLAG);

   cnt8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_sel (edge_fall),
      .edge_o   (pin_edge)
   );

   assign src_tick = src_ext ? pin_edge : icyc_en;
   assign pre_in   = psa_sel ? wdt_base : src_tick;

   cnt8_prescaler #(.RATE_W(RATE_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_tick   (pre_in),
      .clr       (cnt_wr && !psa_sel),
      .for_timer (!psa_sel),
      .rate      (rate_sel),
      .tick_o    (pre_tick)
   );

   assign tmr_tick = psa_sel ? src_tick : pre_tick;
   assign wdt_tick = psa_sel ? pre_tick : wdt_base;
   assign wrap     = tmr_tick && !cnt_wr && (count_q == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      opt_q <= '1;
      else if (opt_wr) opt_q <= wr_data[OPT_W-1:0];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        count_q <= '0;
      else if (cnt_wr)   count_q <= wr_data;
      else if (tmr_tick) count_q <= count_q + 1'b1;

   // a wrap beats a clearing write on the same clock
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (wrap)    ovf_flag <= 1'b1;
      else if (flag_wr) ovf_flag <= wr_data[0];
endmodule

// File: rtl/cnt8_checker.sv
module cnt8_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [CNT_W-1:0] wr_data,
   input logic             wdt_base,
   input logic [CNT_W-1:0] count_q,
   input logic             ovf_flag,
   input logic             wdt_tick,
   input logic             psa_q
);
   import cnt8_pkg::*;

   logic cnt_wr_c;
   assign cnt_wr_c = wr_en && (wr_sel == SEL_CNT);

   // R2: without a load the counter only holds or steps by one
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_wr_c) && (count_q != $past(count_q)))
         |-> (count_q == $past(count_q) + 1'b1));

   // R3: a wrap leaves the flag set
   p_wrap_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_wr_c) && ($past(count_q) == {CNT_W{1'b1}}) && (count_q == '0))
         |-> ovf_flag);

   // R4: the flag only drops after a clearing flag write
   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag) |-> $past(wr_en && (wr_sel == SEL_FLAG) && !wr_data[0]));

   // R7: watchdog side bypasses when the prescaler serves the timer
   p_wdt_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !psa_q |-> (wdt_tick == wdt_base));

   // R8: a counter write lands on the next clock
   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_c |=> (count_q == $past(wr_data)));
endmodule

bind cnt8_presc_timer cnt8_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .wdt_base (wdt_base),
   .count_q  (count_q),
   .ovf_flag (ovf_flag),
   .wdt_tick (wdt_tick),
   .psa_q    (psa_sel)
);

// File: tb/sim_cnt8_presc_timer.sv
module sim_cnt8_presc_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       icyc_en = 1'b1;
   logic       ext_pin = 1'b0;
   logic       wdt_base = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] count_q;
   logic       ovf_flag;
   logic       wdt_tick;

   int checks = 0;
   int failures = 0;
   int wdt_seen = 0;
   bit done = 1'b0;

   typedef struct {
      string      tag;
      logic [7:0] cnt;
      logic       flg;
      int         wdt;
      bit         chk_wdt;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   cnt8_presc_timer u0 (
      .clk(clk), .rst_n(rst_n), .icyc_en(icyc_en), .ext_pin(ext_pin),
      .wdt_base(wdt_base), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .count_q(count_q), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
   );

   always @(posedge clk) if (rst_n && wdt_tick) wdt_seen <= wdt_seen + 1;

   // monitor: pops expectations and compares against the ports
   initial forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (count_q !== e.cnt) begin
            failures++;
            $display("FAIL %s count actual=%h expected=%h", e.tag, count_q, e.cnt);
         end
         checks++;
         if (ovf_flag !== e.flg) begin
            failures++;
            $display("FAIL %s flag actual=%b expected=%b", e.tag, ovf_flag, e.flg);
         end
         if (e.chk_wdt) begin
            checks++;
            if (wdt_seen != e.wdt) begin
               failures++;
               $display("FAIL %s wdt_tick count actual=%0d expected=%0d", e.tag, wdt_seen, e.wdt);
            end
         end
      end
   end

   task automatic expect_st(input string tag, input logic [7:0] c, input logic f);
      exp_t e;
      e.tag = tag; e.cnt = c; e.flg = f; e.wdt = 0; e.chk_wdt = 1'b0;
      q.push_back(e);
      #3;
   endtask

   task automatic expect_wdt(input string tag, input logic [7:0] c, input logic f, input int w);
      exp_t e;
      e.tag = tag; e.cnt = c; e.flg = f; e.wdt = w; e.chk_wdt = 1'b1;
      q.push_back(e);
      #3;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wdt_pulses(input int n);
      repeat (n) begin
         wdt_base = 1'b1; @(negedge clk);
         wdt_base = 1'b0; @(negedge clk);
      end
   endtask

   task automatic pin_pulse();
      ext_pin = 1'b1; tick(4);
      ext_pin = 1'b0; tick(4);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      expect_st("R1 reset", 8'h00, 1'b0);
      tick(5);
      expect_st("R1 external default, no count", 8'h00, 1'b0);

      // R9 option write: internal source, prescaler on watchdog, rate 0
      wr(2'd1, 8'h04);
      tick(10);
      expect_st("R2 R9 internal count", 8'd10, 1'b0);
      for (int i = 0; i < 6; i++) begin
         icyc_en = (i % 2 == 0);
         @(negedge clk);
      end
      icyc_en = 1'b1;
      expect_st("R2 gated count", 8'd13, 1'b0);

      wr(2'd0, 8'hF0);
      expect_st("R8 load beats increment", 8'hF0, 1'b0);
      tick(15);
      expect_st("R3 before wrap", 8'hFF, 1'b0);
      tick(1);
      expect_st("R3 wrap sets flag", 8'h00, 1'b1);
      tick(3);
      expect_st("R3 flag sticky", 8'h03, 1'b1);

      icyc_en = 1'b0;
      wr(2'd2, 8'h00);
      expect_st("R4 clear flag", 8'h03, 1'b0);
      wr(2'd0, 8'hFF);
      icyc_en = 1'b1;
      wr(2'd2, 8'h00);
      icyc_en = 1'b0;
      expect_st("R4 wrap wins over clear", 8'h00, 1'b1);
      wr(2'd2, 8'h00);
      expect_st("R4 clear after tie", 8'h00, 1'b0);

      // R6 prescaler on timer, rate 1 -> 1:4
      wr(2'd1, 8'h08);
      wr(2'd0, 8'h00);
      icyc_en = 1'b1; tick(12); icyc_en = 1'b0;
      expect_st("R6 ratio 1:4", 8'd3, 1'b0);
      // rate 7 -> 1:256
      wr(2'd1, 8'h38);
      wr(2'd0, 8'h00);
      icyc_en = 1'b1; tick(255); icyc_en = 1'b0;
      expect_st("R6 ratio 1:256 before", 8'd0, 1'b0);
      icyc_en = 1'b1; tick(1); icyc_en = 1'b0;
      expect_st("R6 ratio 1:256 step", 8'd1, 1'b0);

      // R8 counter write clears prescaler
      wr(2'd1, 8'h08);
      wr(2'd0, 8'h00);
      icyc_en = 1'b1; tick(3); icyc_en = 1'b0;
      expect_st("R8 partial prescale", 8'd0, 1'b0);
      wr(2'd0, 8'h10);
      icyc_en = 1'b1; tick(3); icyc_en = 1'b0;
      expect_st("R8 prescaler cleared by load", 8'h10, 1'b0);
      icyc_en = 1'b1; tick(1); icyc_en = 1'b0;
      expect_st("R8 first step after load", 8'h11, 1'b0);

      // R7 watchdog side
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h14);
      wdt_seen = 0;
      wdt_pulses(8);
      expect_wdt("R7 watchdog 1:4", 8'd0, 1'b0, 2);
      wr(2'd1, 8'h04);
      wdt_seen = 0;
      wdt_pulses(5);
      expect_wdt("R7 watchdog 1:1", 8'd0, 1'b0, 5);
      wr(2'd1, 8'h08);
      wdt_seen = 0;
      wdt_pulses(3);
      expect_wdt("R7 bypass, timer untouched", 8'd0, 1'b0, 3);

      // R5 external source
      icyc_en = 1'b1;
      wr(2'd1, 8'h05);
      wr(2'd0, 8'h00);
      pin_pulse(); pin_pulse(); pin_pulse();
      expect_st("R5 rising edges, enable ignored", 8'd3, 1'b0);
      wr(2'd1, 8'h07);
      wr(2'd0, 8'h00);
      ext_pin = 1'b1; tick(4);
      expect_st("R5 falling mode ignores rise", 8'd0, 1'b0);
      ext_pin = 1'b0; tick(4);
      expect_st("R5 falling edge counted", 8'd1, 1'b0);

      tick(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule